// File: doc/BRIEF.md
# Receive FIFO packet drain controller

This block empties one packet from a receive byte FIFO while the radio side is still writing bytes into it. The FIFO's occupancy count is treated as unreliable while it moves: the controller samples it repeatedly and acts only on a value seen in two consecutive samples. It then reads a safe number of bytes and returns to sampling, until every byte of the packet has been read.

A start pulse loads the packet length, which is the number of bytes still to read. While the agreed occupancy is smaller than that remainder, the controller reads one byte fewer than the agreed count. The last byte is therefore held back until the whole rest of the packet is known to be present. Once the agreed occupancy covers the remainder, the controller reads exactly the remainder and raises a done pulse. The FIFO is assumed to return read data one cycle after a read strobe. The occupancy count must be sampled at least twice as often as bytes arrive; the `SAMPLE_DIV` parameter sets the sampling interval in clocks.

Top module: `rx_drain_ctrl`

## Requirements
- R1: During and after the active-low synchronous reset, `fifo_rd`, `out_valid` and `done` are low. No read strobe is issued before a start pulse, whatever the FIFO holds.
- R2: No read is issued until two consecutive occupancy samples are equal. An occupancy count that changes at every sample produces no reads.
- R3: When the agreed occupancy n is less than the bytes remaining and n is at least 2, exactly n-1 read strobes are issued on consecutive clocks, and then sampling starts again.
- R4: When the agreed occupancy n is equal to or greater than the bytes remaining, exactly the remaining number of bytes is read on consecutive clocks. Any bytes beyond the packet stay in the FIFO. The packet then finishes.
- R5: When the agreed occupancy is 0 or 1 and more bytes are still needed, no read is issued and sampling continues.
- R6: The total number of read strobes for one packet equals the loaded packet length, with at most one strobe per clock.
- R7: Each read strobe produces, two clocks later, a one-cycle `out_valid` pulse. `out_data` carries the byte the FIFO returned one clock after the strobe, and bytes leave in FIFO order.
- R8: `done` is a one-cycle pulse that coincides with the `out_valid` of the packet's last byte. A start with length 0 issues no reads and gives `done` two clocks after the start pulse.
- R9: A start pulse that arrives while a packet is being drained is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins draining a packet |
| pkt_len | input | LEN_W (8) | Bytes to read for the packet, captured on start |
| fifo_count | input | CNT_W (7) | FIFO occupancy count, 0 to 64, possibly changing |
| fifo_rdata | input | DATA_W (8) | FIFO read data, valid one clock after a strobe |
| fifo_rd | output | 1 | FIFO read strobe |
| out_valid | output | 1 | Byte-valid pulse for out_data |
| out_data | output | DATA_W (8) | Byte read from the FIFO |
| done | output | 1 | One-cycle pulse at the packet's last byte |

## Verification
Bytes already waiting before start, with a pause afterwards, show that a partial pass reads exactly n-1 bytes and then stalls while a single byte remains. A forced occupancy count that toggles between two values shows that an unstable count never triggers a read. A FIFO that holds more than the packet, followed by a second packet, separates "read the remainder" from "read the occupancy", and a byte trickle at a quarter of the clock rate exercises many small passes and the final full pass. A zero-length start and a start pulse in the middle of a packet cover the edge cases of the done pulse and of the ignored start.

// File: rtl/rxd_pkg.sv
// Package: shared types for the receive FIFO drain controller.
// Assumes nothing beyond the standard type system.
package rxd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_READ   = 2'd2
    } rxd_state_e;
endpackage

// File: rtl/rxd_stable_sampler.sv
// Module: rxd_stable_sampler
// Samples the FIFO occupancy count every SAMPLE_DIV clocks while enabled
// and flags agreement when a sample equals the previous one.
// Assumes: the caller drops enable whenever it leaves the sampling phase,
// so every new phase needs two fresh samples.
module rxd_stable_sampler #(
    parameter int CNT_W      = 7,
    parameter int SAMPLE_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    output logic             agree,
    output logic [CNT_W-1:0] agreed_n
);
    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] prev;
    logic             have_prev;
    logic             tick;

    generate
        if (SAMPLE_DIV > 1) begin : g_div
            // Divider: paces the samples while enabled.
            always_ff @(posedge clk) begin
                if (!rst_n || !enable) begin
                    div_cnt <= '0;
                end else if (div_cnt == DIV_W'(SAMPLE_DIV - 1)) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
            assign tick = enable && (div_cnt == '0);
        end else begin : g_nodiv
            // No divider: sample on every enabled clock.
            always_ff @(posedge clk) begin
                div_cnt <= '0;
            end
            assign tick = enable;
        end
    endgenerate

    // Sample store: keeps the previous sample of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            prev      <= '0;
            have_prev <= 1'b0;
        end else if (tick) begin
            prev      <= count;
            have_prev <= 1'b1;
        end
    end

    assign agree    = tick && have_prev && (count == prev);
    assign agreed_n = count;
endmodule

// File: rtl/rxd_burst_ctrl.sv
// Module: rxd_burst_ctrl
// Sequencer: holds the bytes-remaining counter, decides each read burst
// from the agreed occupancy, and issues one read strobe per clock.
// Assumes: the agreed occupancy never counts more than the FIFO holds.
module rxd_burst_ctrl
    import rxd_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             agree,
    input  logic [CNT_W-1:0] agreed_n,
    output logic             sample_en,
    output logic             rd,
    output logic             end_tag
);
    localparam int CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

    rxd_state_e       state;
    logic [LEN_W-1:0] rem;
    logic [CNT_W-1:0] burst;
    logic             last_burst;
    logic [CMP_W-1:0] n_ext;
    logic [CMP_W-1:0] rem_ext;
    logic             covers_rest;
    logic             worth_read;
    logic             final_strobe;

    assign n_ext        = CMP_W'(agreed_n);
    assign rem_ext      = CMP_W'(rem);
    assign covers_rest  = (n_ext >= rem_ext);
    assign worth_read   = (agreed_n > CNT_W'(1));
    assign sample_en    = (state == ST_SAMPLE);
    assign rd           = (state == ST_READ);
    assign final_strobe = rd && last_burst && (burst == CNT_W'(1));
    assign end_tag      = final_strobe ||
                          ((state == ST_IDLE) && start && (pkt_len == '0));

    // Control state, remaining counter and burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rem        <= '0;
            burst      <= '0;
            last_burst <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && (pkt_len != '0)) begin
                        rem   <= pkt_len;
                        state <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    if (agree) begin
                        if (covers_rest) begin
                            burst      <= CNT_W'(rem_ext);
                            last_burst <= 1'b1;
                            state      <= ST_READ;
                        end else if (worth_read) begin
                            burst      <= agreed_n - CNT_W'(1);
                            last_burst <= 1'b0;
                            state      <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    rem   <= rem - LEN_W'(1);
                    burst <= burst - CNT_W'(1);
                    if (burst == CNT_W'(1)) begin
                        state <= last_burst ? ST_IDLE : ST_SAMPLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxd_out_pipe.sv
// Module: rxd_out_pipe
// Output stage: turns read strobes into byte-valid pulses aligned with the
// FIFO data, and delays the end tag so done meets the last byte.
// Assumes: the FIFO presents read data one clock after the strobe.
module rxd_out_pipe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              end_tag,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              done
);
    logic rd_q;
    logic end_q;

    // Stage one: remembers which clocks carried a strobe or the end tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            end_q <= 1'b0;
        end else begin
            rd_q  <= rd;
            end_q <= end_tag;
        end
    end

    // Stage two: captures the returned byte and raises valid and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= rd_q;
            done      <= end_q;
            if (rd_q) begin
                out_data <= fifo_rdata;
            end
        end
    end
endmodule

// File: rtl/rx_drain_ctrl.sv
// Module: rx_drain_ctrl (top)
// Drains one packet from a receive FIFO that is still being filled: it
// waits for a stable occupancy, reads all but one byte while the packet is
// incomplete, and reads the exact remainder once it is all present.
// Assumes: occupancy is sampled at least twice per byte arrival, and the
// FIFO returns read data one clock after a strobe.
module rx_drain_ctrl #(
    parameter int LEN_W      = 8,
    parameter int CNT_W      = 7,
    parameter int DATA_W     = 8,
    parameter int SAMPLE_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_rd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              done
);
    logic             sample_en;
    logic             agree;
    logic [CNT_W-1:0] agreed_n;
    logic             end_tag;

    rxd_stable_sampler #(
        .CNT_W      (CNT_W),
        .SAMPLE_DIV (SAMPLE_DIV)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (sample_en),
        .count    (fifo_count),
        .agree    (agree),
        .agreed_n (agreed_n)
    );

    rxd_burst_ctrl #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pkt_len   (pkt_len),
        .agree     (agree),
        .agreed_n  (agreed_n),
        .sample_en (sample_en),
        .rd        (fifo_rd),
        .end_tag   (end_tag)
    );

    rxd_out_pipe #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (fifo_rd),
        .end_tag    (end_tag),
        .fifo_rdata (fifo_rdata),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .done       (done)
    );
endmodule

// File: rtl/rx_drain_ctrl_chk.sv
// Module: rx_drain_ctrl_chk
// Checker bound to rx_drain_ctrl: watches only the top-level ports and
// keeps its own record of the packet in progress.
// Assumes: the same parameters as the bound instance.
module rx_drain_ctrl_chk #(
    parameter int LEN_W      = 8,
    parameter int CNT_W      = 7,
    parameter int SAMPLE_DIV = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] pkt_len,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_rd,
    input logic             out_valid,
    input logic             done
);
    logic             busy;
    logic [LEN_W-1:0] len_l;
    logic [LEN_W-1:0] strobes;

    // Packet record: length taken at an accepted start, strobes counted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            len_l   <= '0;
            strobes <= '0;
        end else if (!busy) begin
            if (start && (pkt_len != '0)) begin
                busy    <= 1'b1;
                len_l   <= pkt_len;
                strobes <= '0;
            end
        end else if (fifo_rd) begin
            strobes <= strobes + LEN_W'(1);
            if (strobes + LEN_W'(1) == len_l) begin
                busy <= 1'b0;
            end
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!fifo_rd && !out_valid && !done));

    a_r6_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (busy && (strobes < len_l)));

    a_r4_read_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (fifo_count != '0));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(fifo_rd, 2));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    generate
        if (SAMPLE_DIV == 1) begin : g_agree_chk
            a_r2_first_read_agreed: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fifo_rd) |-> ($past(fifo_count) == $past(fifo_count, 2)));
        end
    endgenerate
endmodule

bind rx_drain_ctrl rx_drain_ctrl_chk #(
    .LEN_W      (LEN_W),
    .CNT_W      (CNT_W),
    .SAMPLE_DIV (SAMPLE_DIV)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pkt_len    (pkt_len),
    .fifo_count (fifo_count),
    .fifo_rd    (fifo_rd),
    .out_valid  (out_valid),
    .done       (done)
);

// File: tb/test_rx_drain_ctrl.sv
// Bench: a FIFO model fed by a radio driver; every byte the driver writes
// goes into an expected queue that the monitor compares against out_data.
module test_rx_drain_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] pkt_len = '0;
    logic [6:0] fifo_count;
    logic [7:0] fifo_rdata = '0;
    logic       fifo_rd;
    logic       out_valid;
    logic [7:0] out_data;
    logic       done;

    always #2 clk = ~clk;

    rx_drain_ctrl i_rx_drain_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pkt_len    (pkt_len),
        .fifo_count (fifo_count),
        .fifo_rdata (fifo_rdata),
        .fifo_rd    (fifo_rd),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .done       (done)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] fifo_q[$];
    logic [7:0] exp_q[$];
    logic [6:0] model_cnt = '0;
    logic       push_req = 1'b0;
    logic [7:0] push_byte = '0;
    logic       force_en = 1'b0;
    logic [6:0] force_val = '0;
    logic [7:0] next_byte = 8'h30;

    assign fifo_count = force_en ? force_val : model_cnt;

    // FIFO model: push, then pop, then publish the occupancy.
    always @(posedge clk) begin
        if (!rst_n) begin
            fifo_q.delete();
            model_cnt <= '0;
        end else begin
            if (push_req) fifo_q.push_back(push_byte);
            if (fifo_rd && fifo_q.size() > 0) fifo_rdata <= fifo_q.pop_front();
            model_cnt <= 7'(fifo_q.size());
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int  cyc = 0;
    int  pkt_strobes = 0;
    int  win_strobes = 0;
    int  first_rd = -1;
    int  last_rd = -1;
    int  done_cnt = 0;
    int  cur_len = 0;
    logic rd_h1 = 1'b0, rd_h2 = 1'b0, done_h = 1'b0;

    // Monitor: strobe bookkeeping, valid timing, scoreboard and done checks.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (out_valid || rd_h2)
                check(out_valid == rd_h2, "R7 valid two clocks after strobe", out_valid, rd_h2);
            if (out_valid) begin
                if (exp_q.size() == 0) check(0, "R7 unexpected byte", out_data, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R7 byte order", out_data, e);
                end
            end
            if (fifo_rd) begin
                pkt_strobes++;
                win_strobes++;
                if (first_rd < 0) first_rd = cyc;
                last_rd = cyc;
            end
            if (done) begin
                done_cnt++;
                check(!done_h, "R8 done one cycle", done_h, 0);
                check(pkt_strobes == cur_len, "R6 strobes per packet", pkt_strobes, cur_len);
                if (cur_len != 0)
                    check(out_valid, "R8 done with last byte", out_valid, 1);
            end
        end
        rd_h2 = rd_h1;
        rd_h1 = fifo_rd;
        done_h = done;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic radio_send(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_req = 1'b1;
            push_byte = next_byte;
            exp_q.push_back(next_byte);
            next_byte = next_byte + 8'd7;
            @(negedge clk);
            push_req = 1'b0;
            if (gap > 2) idle(gap - 2);
        end
    endtask

    task automatic start_pkt(input int len);
        @(negedge clk);
        pkt_strobes = 0;
        first_rd = -1;
        cur_len = len;
        start = 1'b1;
        pkt_len = 8'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int d0;
        int t;
        d0 = done_cnt;
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(done_cnt != d0, req, 0, 1);
        idle(1);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(!fifo_rd && !out_valid && !done, "R1 outputs low in reset", fifo_rd, 0);
        rst_n = 1'b1;
        idle(2);
        check(!fifo_rd && !out_valid && !done, "R1 outputs low after reset", out_valid, 0);

        // R1: bytes waiting but no start.
        radio_send(6, 1);
        win_strobes = 0;
        idle(12);
        check(win_strobes == 0, "R1 no read before start", win_strobes, 0);

        // R3: six waiting bytes, packet of 20: exactly five reads.
        start_pkt(20);
        win_strobes = 0;
        idle(14);
        check(win_strobes == 5, "R3 n-1 reads", win_strobes, 5);
        check(last_rd - first_rd == 4, "R3 consecutive reads", last_rd - first_rd, 4);
        check(fifo_q.size() == 1, "R3 one byte held back", fifo_q.size(), 1);
        // R5: one byte present, more needed: no reads.
        win_strobes = 0;
        idle(30);
        check(win_strobes == 0, "R5 no read at n=1", win_strobes, 0);
        radio_send(14, 4);
        wait_done("R4 packet of 20 finishes");

        // R2: unstable occupancy gives no reads.
        radio_send(10, 1);
        force_en = 1'b1;
        force_val = 7'd10;
        start_pkt(10);
        win_strobes = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            force_val = (force_val == 7'd10) ? 7'd11 : 7'd10;
        end
        check(win_strobes == 0, "R2 no read on changing count", win_strobes, 0);
        force_en = 1'b0;
        wait_done("R2 packet finishes after count settles");

        // R4: twelve waiting bytes, packet of 8: reads exactly 8.
        radio_send(12, 1);
        start_pkt(8);
        wait_done("R4 packet of 8 finishes");
        check(pkt_strobes == 8, "R4 exact remainder read", pkt_strobes, 8);
        check(last_rd - first_rd == 7, "R4 consecutive reads", last_rd - first_rd, 7);
        check(fifo_q.size() == 4, "R4 extra bytes stay", fifo_q.size(), 4);
        start_pkt(4);
        wait_done("R4 leftover packet finishes");
        check(fifo_q.size() == 0, "R4 FIFO empty", fifo_q.size(), 0);

        // R8: zero-length packet.
        start_pkt(0);
        check(!done, "R8 no done one clock after start", done, 0);
        @(negedge clk);
        check(done, "R8 done two clocks after start", done, 1);
        check(pkt_strobes == 0, "R8 no reads for zero length", pkt_strobes, 0);
        idle(3);

        // R9: start during a packet is ignored.
        radio_send(3, 1);
        start_pkt(6);
        idle(4);
        @(negedge clk);
        start = 1'b1;
        pkt_len = 8'd2;
        @(negedge clk);
        start = 1'b0;
        radio_send(3, 4);
        wait_done("R9 packet finishes");
        check(pkt_strobes == 6, "R9 length unchanged", pkt_strobes, 6);
        win_strobes = 0;
        idle(20);
        check(win_strobes == 0, "R9 no second packet", win_strobes, 0);
        check(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule